// File: doc/BRIEF.md
# Hybrid-Memory-Aware Cache Replacement Controller

This block is the policy engine for a group of sets in a shared last-level cache that sits in front of a main memory made of DRAM and slow-write NVM. Tags, data arrays and the memory port are outside it. For every lookup the surrounding cache supplies the set index, the hit result and the hit way, the backing memory type of the address, the number of distinct addresses in the warp request that produced the lookup, and whether the access writes. The block keeps a 2-bit retention priority, a valid bit, a dirty bit and a memory-type bit for each way. It answers with the way to use, whether a line was allocated, whether the fill was bypassed, and the priority now held by that way.

Each line falls into one of four classes, formed from its memory type and from whether its request was coalesced or divergent. In static mode, fixed per-class tables give the priority a line gets on a fill and the amount added on a hit. NVM classes get larger values, so refetch-expensive lines stay longer. Counters per class run over an epoch of accepted lookups. When the per-request dynamic flag is set, the block applies what the last completed epoch learned: it bypasses classes that rarely hit, and it adds one to the insertion and promotion values of classes that hit often.

Lookups use a valid/ready handshake. `req_ready` is low exactly while a writeback request is pending, so a held writeback back-pressures new lookups. A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears for one cycle after that edge and has no back-pressure. The writeback output is valid/ready as well: once raised it holds its fields until `wb_ready` is seen high at a clock edge.

Top module: `hmrc_top`

## Requirements
- R1: The class index is {memory type, divergent}, where memory type is 1 for NVM and divergent is 1 when `req_naddr` > COAL_MAX (default 2). Class 0 is DRAM coalesced, 1 is DRAM divergent, 2 is NVM coalesced and 3 is NVM divergent.
- R2: On an allocating miss, the new line gets the static insertion priority of its class: class 0 gets 1, class 1 gets 0, class 2 gets 2 and class 3 gets 1. These are the 2-bit fields of INS_TAB, with class c at bits [2c+1:2c].
- R3: On a hit, the way's priority becomes the saturating sum (maximum 3) of its old value and the class promotion amount from PROMO_TAB: class 0 adds 1, class 1 adds 1, class 2 adds 3 and class 3 adds 2. A write hit marks the way dirty.
- R4: The victim for an allocating miss is the lowest-index invalid way if there is one. Otherwise it is the lowest-index way holding the minimum priority, and every way of the set first has that minimum subtracted from it.
- R5: Evicting a valid dirty line raises `wb_valid` with the set, the way and the line's memory type. These fields stay stable until `wb_ready` is sampled high, and `req_ready` is low for as long as `wb_valid` is high.
- R6: `rsp_valid` is high for exactly the cycle after each accepted lookup, carrying `rsp_way`, `rsp_fill` (1 for an allocation), `rsp_bypass` and `rsp_prio`. On a bypass, `rsp_way` and `rsp_prio` are 0.
- R7: Per class, hits and misses are counted over EPOCH accepted lookups in either mode. At the end of the epoch, a class with at least one access and 8·hits < accesses is marked for bypass for the next epoch.
- R8: At the end of the epoch, a class with 2·hits > accesses is boosted for the next epoch: its insertion priority and its promotion amount are each raised by one, saturating at 3.
- R9: Bypass and boost take effect only for lookups with `req_dyn` = 1. A bypassed miss allocates nothing, changes no way state, raises no writeback and returns `rsp_fill` = 0 with `rsp_bypass` = 1.
- R10: Reset (`rst_n` low) clears every way to invalid and clean and clears all dynamic state. It leaves `rsp_valid` = 0, `wb_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup accepted when high together with req_valid |
| req_set | input | SET_W | Set index within the group |
| req_hit | input | 1 | Tag lookup hit |
| req_hit_way | input | WAY_W | Way that hit |
| req_nvm | input | 1 | Address backed by NVM (1) or DRAM (0) |
| req_naddr | input | NADDR_W | Distinct addresses in the originating warp request |
| req_write | input | 1 | Access writes the line |
| req_dyn | input | 1 | Apply the learned dynamic policy |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_way | output | WAY_W | Way hit or allocated |
| rsp_fill | output | 1 | A line was allocated |
| rsp_bypass | output | 1 | Miss was bypassed |
| rsp_prio | output | 2 | New priority of the affected way |
| wb_valid | output | 1 | Dirty victim writeback request |
| wb_ready | input | 1 | Writeback accepted |
| wb_set | output | SET_W | Set of the dirty victim |
| wb_way | output | WAY_W | Way of the dirty victim |
| wb_nvm | output | 1 | Memory type of the dirty victim |

## Verification
The bench targets the tie cases in victim choice. A design that picked the highest index, or that aged the ways when a free way existed, would return the wrong way and the wrong priority on later lookups. It covers saturation on promotion and the coalescing boundary at exactly COAL_MAX addresses, where an off-by-one puts a line in the divergent class and gives it a lower insertion value. It holds `wb_ready` low to catch a writeback that drops or changes its fields, or a controller that keeps accepting lookups and loses the victim. It forms complete epochs of known content to show that bypass and boost appear only with the dynamic flag and only after the epoch ends, and that a reset wipes them.

// File: rtl/hmrc_pkg.sv
package hmrc_pkg;
  localparam int NCLS = 4;
  typedef logic [1:0] prio_t;
  typedef logic [1:0] cls_t;

  function automatic cls_t make_cls(input logic nvm, input logic divergent);
    return {nvm, divergent};
  endfunction

  function automatic prio_t sat_add(input prio_t a, input prio_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[2] ? 2'd3 : s[1:0];
  endfunction
endpackage

// File: rtl/hmrc_policy.sv
module hmrc_policy
  import hmrc_pkg::*;
#(
  parameter int NADDR_W   = 6,
  parameter int COAL_MAX  = 2,
  parameter logic [7:0] INS_TAB   = 8'h61,
  parameter logic [7:0] PROMO_TAB = 8'hB5
) (
  input  logic               nvm,
  input  logic [NADDR_W-1:0] naddr,
  input  logic               dyn,
  input  logic [NCLS-1:0]    byp_vec,
  input  logic [NCLS-1:0]    boost_vec,
  output cls_t               cls,
  output prio_t              ins_prio,
  output prio_t              promo,
  output logic               bypass
);
  localparam logic [NADDR_W-1:0] COAL_LIM = NADDR_W'(COAL_MAX);

  logic  divergent;
  prio_t ins_s, promo_s;
  logic  boost_on;

  always_comb begin
    divergent = naddr > COAL_LIM;
    cls       = make_cls(nvm, divergent);
    ins_s     = INS_TAB[{cls, 1'b0} +: 2];
    promo_s   = PROMO_TAB[{cls, 1'b0} +: 2];
    boost_on  = dyn && boost_vec[cls];
    ins_prio  = boost_on ? sat_add(ins_s, 2'd1) : ins_s;
    promo     = boost_on ? sat_add(promo_s, 2'd1) : promo_s;
    bypass    = dyn && byp_vec[cls];
  end
endmodule

// File: rtl/hmrc_epoch_monitor.sv
module hmrc_epoch_monitor
  import hmrc_pkg::*;
#(
  parameter int EPOCH = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  cls_t            acc_cls,
  input  logic            acc_hit,
  output logic [NCLS-1:0] byp_vec,
  output logic [NCLS-1:0] boost_vec
);
  localparam int CW = $clog2(EPOCH) + 1;
  localparam int XW = CW + 4;

  logic [CW-1:0] ep_cnt;
  logic          ep_end;

  assign ep_end = acc && (ep_cnt == CW'(EPOCH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      ep_cnt <= '0;
    else if (ep_end) ep_cnt <= '0;
    else if (acc)    ep_cnt <= ep_cnt + 1'b1;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic [CW-1:0] hits_q, miss_q, hits_n, miss_n;
    logic [XW-1:0] tot, h8, h2;
    logic          sel;

    always_comb begin
      sel    = acc && (acc_cls == cls_t'(c));
      hits_n = hits_q + CW'(sel && acc_hit);
      miss_n = miss_q + CW'(sel && !acc_hit);
      tot    = XW'(hits_n) + XW'(miss_n);
      h8     = XW'(hits_n) << 3;
      h2     = XW'(hits_n) << 1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hits_q       <= '0;
        miss_q       <= '0;
        byp_vec[c]   <= 1'b0;
        boost_vec[c] <= 1'b0;
      end else if (ep_end) begin
        hits_q       <= '0;
        miss_q       <= '0;
        byp_vec[c]   <= (tot != '0) && (h8 < tot);
        boost_vec[c] <= h2 > tot;
      end else begin
        hits_q <= hits_n;
        miss_q <= miss_n;
      end
    end
  end
endmodule

// File: rtl/hmrc_victim_select.sv
module hmrc_victim_select
  import hmrc_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [2*WAYS-1:0] prio_row,
  input  logic [WAYS-1:0]   valid_row,
  output logic [WAY_W-1:0]  victim,
  output logic              has_free,
  output logic [2*WAYS-1:0] aged_row
);
  prio_t            minp;
  logic [WAY_W-1:0] free_w, min_w;
  logic             min_found;

  always_comb begin
    minp = 2'd3;
    for (int w = 0; w < WAYS; w++) begin
      if (prio_row[2*w +: 2] < minp) minp = prio_row[2*w +: 2];
    end

    has_free = 1'b0;
    free_w   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w]) begin
        has_free = 1'b1;
        free_w   = WAY_W'(w);
      end
    end

    min_found = 1'b0;
    min_w     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (prio_row[2*w +: 2] == minp) begin
        min_found = 1'b1;
        min_w     = WAY_W'(w);
      end
    end

    victim = has_free ? free_w : min_w;
    for (int w = 0; w < WAYS; w++) begin
      aged_row[2*w +: 2] = has_free ? prio_row[2*w +: 2]
                                    : prio_row[2*w +: 2] - minp;
    end
  end
endmodule

// File: rtl/hmrc_top.sv
module hmrc_top
  import hmrc_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int SETS      = 8,
  parameter int NADDR_W   = 6,
  parameter int COAL_MAX  = 2,
  parameter int EPOCH     = 1024,
  parameter logic [7:0] INS_TAB   = 8'h61,
  parameter logic [7:0] PROMO_TAB = 8'hB5,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [SET_W-1:0]   req_set,
  input  logic               req_hit,
  input  logic [WAY_W-1:0]   req_hit_way,
  input  logic               req_nvm,
  input  logic [NADDR_W-1:0] req_naddr,
  input  logic               req_write,
  input  logic               req_dyn,
  output logic               rsp_valid,
  output logic [WAY_W-1:0]   rsp_way,
  output logic               rsp_fill,
  output logic               rsp_bypass,
  output logic [1:0]         rsp_prio,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [SET_W-1:0]   wb_set,
  output logic [WAY_W-1:0]   wb_way,
  output logic               wb_nvm
);
  logic [2*WAYS-1:0] prio_q  [SETS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAYS-1:0]   nvm_q   [SETS];

  logic            acc;
  cls_t            cls;
  prio_t           ins_prio, promo, hit_new;
  logic            pol_bypass;
  logic [NCLS-1:0] byp_vec, boost_vec;

  logic [WAY_W-1:0]  victim;
  logic              has_free;
  logic [2*WAYS-1:0] aged_row;

  logic [2*WAYS-1:0] n_prio;
  logic [WAYS-1:0]   n_valid, n_dirty, n_nvm;
  logic [WAY_W-1:0]  r_way;
  logic              r_fill, r_byp, wb_new, wb_n;
  prio_t             r_prio;

  assign req_ready = !wb_valid;
  assign acc       = req_valid && req_ready;

  hmrc_policy #(
    .NADDR_W(NADDR_W), .COAL_MAX(COAL_MAX),
    .INS_TAB(INS_TAB), .PROMO_TAB(PROMO_TAB)
  ) policy_i (
    .nvm(req_nvm), .naddr(req_naddr), .dyn(req_dyn),
    .byp_vec(byp_vec), .boost_vec(boost_vec),
    .cls(cls), .ins_prio(ins_prio), .promo(promo), .bypass(pol_bypass)
  );

  hmrc_epoch_monitor #(.EPOCH(EPOCH)) epoch_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .acc_cls(cls), .acc_hit(req_hit),
    .byp_vec(byp_vec), .boost_vec(boost_vec)
  );

  hmrc_victim_select #(.WAYS(WAYS)) victim_i (
    .prio_row(prio_q[req_set]), .valid_row(valid_q[req_set]),
    .victim(victim), .has_free(has_free), .aged_row(aged_row)
  );

  always_comb begin
    n_prio  = prio_q[req_set];
    n_valid = valid_q[req_set];
    n_dirty = dirty_q[req_set];
    n_nvm   = nvm_q[req_set];
    r_way   = '0;
    r_fill  = 1'b0;
    r_byp   = 1'b0;
    r_prio  = '0;
    wb_new  = 1'b0;
    wb_n    = 1'b0;
    hit_new = sat_add(n_prio[{req_hit_way, 1'b0} +: 2], promo);
    if (req_hit) begin
      n_prio[{req_hit_way, 1'b0} +: 2] = hit_new;
      if (req_write) n_dirty[req_hit_way] = 1'b1;
      r_way  = req_hit_way;
      r_prio = hit_new;
    end else if (pol_bypass) begin
      r_byp = 1'b1;
    end else begin
      n_prio = aged_row;
      if (!has_free && dirty_q[req_set][victim]) begin
        wb_new = 1'b1;
        wb_n   = nvm_q[req_set][victim];
      end
      n_prio[{victim, 1'b0} +: 2] = ins_prio;
      n_valid[victim] = 1'b1;
      n_dirty[victim] = req_write;
      n_nvm[victim]   = req_nvm;
      r_way  = victim;
      r_fill = 1'b1;
      r_prio = ins_prio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        prio_q[s]  <= '0;
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        nvm_q[s]   <= '0;
      end
      rsp_valid  <= 1'b0;
      rsp_way    <= '0;
      rsp_fill   <= 1'b0;
      rsp_bypass <= 1'b0;
      rsp_prio   <= '0;
      wb_valid   <= 1'b0;
      wb_set     <= '0;
      wb_way     <= '0;
      wb_nvm     <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (wb_valid && wb_ready) wb_valid <= 1'b0;
      if (acc) begin
        prio_q[req_set]  <= n_prio;
        valid_q[req_set] <= n_valid;
        dirty_q[req_set] <= n_dirty;
        nvm_q[req_set]   <= n_nvm;
        rsp_way    <= r_way;
        rsp_fill   <= r_fill;
        rsp_bypass <= r_byp;
        rsp_prio   <= r_prio;
        if (wb_new) begin
          wb_valid <= 1'b1;
          wb_set   <= req_set;
          wb_way   <= victim;
          wb_nvm   <= wb_n;
        end
      end
    end
  end
endmodule

// File: rtl/hmrc_checker.sv
module hmrc_checker #(
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_dyn,
  input logic             rsp_valid,
  input logic             rsp_fill,
  input logic             rsp_bypass,
  input logic [WAY_W-1:0] rsp_way,
  input logic [1:0]       rsp_prio,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [SET_W-1:0] wb_set,
  input logic [WAY_W-1:0] wb_way,
  input logic             wb_nvm
);
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R6
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid); // R6
  AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_set) && $stable(wb_way) && $stable(wb_nvm))); // R5
  AST_WB_STALLS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !req_ready); // R5
  AST_WB_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> (rsp_valid && rsp_fill)); // R5
  AST_BYPASS_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bypass) |-> (!rsp_fill && !wb_valid && rsp_way == '0 && rsp_prio == 2'd0)); // R9
  AST_BYPASS_NEEDS_DYN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_bypass) |-> $past(req_dyn)); // R9
endmodule

bind hmrc_top hmrc_checker #(.SET_W(SET_W), .WAY_W(WAY_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_dyn(req_dyn), .rsp_valid(rsp_valid), .rsp_fill(rsp_fill),
  .rsp_bypass(rsp_bypass), .rsp_way(rsp_way), .rsp_prio(rsp_prio),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_set(wb_set),
  .wb_way(wb_way), .wb_nvm(wb_nvm)
);

// File: tb/hmrc_top_tb_top.sv
module hmrc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_hit = 1'b0, req_nvm = 1'b0;
  logic       req_write = 1'b0, req_dyn = 1'b0, wb_ready = 1'b1;
  logic [2:0] req_set = '0;
  logic [1:0] req_hit_way = '0;
  logic [5:0] req_naddr = '0;
  logic       req_ready, rsp_valid, rsp_fill, rsp_bypass, wb_valid, wb_nvm;
  logic [1:0] rsp_way, rsp_prio, wb_way;
  logic [2:0] wb_set;

  int n_chk = 0, n_bad = 0, n_acc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hmrc_top #(.EPOCH(EP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_hit(req_hit), .req_hit_way(req_hit_way),
    .req_nvm(req_nvm), .req_naddr(req_naddr), .req_write(req_write),
    .req_dyn(req_dyn), .rsp_valid(rsp_valid), .rsp_way(rsp_way),
    .rsp_fill(rsp_fill), .rsp_bypass(rsp_bypass), .rsp_prio(rsp_prio),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_set(wb_set),
    .wb_way(wb_way), .wb_nvm(wb_nvm)
  );

  typedef struct packed {
    logic [2:0] set; logic hit; logic [1:0] way; logic nvm;
    logic [5:0] naddr; logic wr;
    logic [1:0] e_way; logic e_fill; logic [1:0] e_prio;
    logic e_wb; logic e_wbnvm; logic [1:0] e_wbway;
  } vec_t;

  // Static mode. Classes per R1: 0 DRAM coal, 1 DRAM div, 2 NVM coal, 3 NVM div.
  localparam vec_t VT [16] = '{
    '{3'd0,1'b0,2'd0,1'b0,6'd1,1'b1, 2'd0,1'b1,2'd1, 1'b0,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b1,6'd1,1'b0, 2'd1,1'b1,2'd2, 1'b0,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b0,6'd8,1'b0, 2'd2,1'b1,2'd0, 1'b0,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b1,6'd8,1'b1, 2'd3,1'b1,2'd1, 1'b0,1'b0,2'd0},
    '{3'd0,1'b1,2'd2,1'b0,6'd1,1'b0, 2'd2,1'b0,2'd1, 1'b0,1'b0,2'd0},
    '{3'd0,1'b1,2'd1,1'b1,6'd1,1'b0, 2'd1,1'b0,2'd3, 1'b0,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b0,6'd4,1'b0, 2'd0,1'b1,2'd0, 1'b1,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b1,6'd1,1'b0, 2'd0,1'b1,2'd2, 1'b0,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b0,6'd1,1'b0, 2'd2,1'b1,2'd1, 1'b0,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b0,6'd1,1'b0, 2'd3,1'b1,2'd1, 1'b1,1'b1,2'd3},
    '{3'd0,1'b1,2'd3,1'b1,6'd8,1'b0, 2'd3,1'b0,2'd3, 1'b0,1'b0,2'd0},
    '{3'd1,1'b0,2'd0,1'b1,6'd8,1'b0, 2'd0,1'b1,2'd1, 1'b0,1'b0,2'd0},
    '{3'd0,1'b0,2'd0,1'b0,6'd8,1'b0, 2'd2,1'b1,2'd0, 1'b0,1'b0,2'd0},
    '{3'd0,1'b1,2'd0,1'b0,6'd8,1'b0, 2'd0,1'b0,2'd2, 1'b0,1'b0,2'd0},
    '{3'd1,1'b0,2'd0,1'b0,6'd2,1'b0, 2'd1,1'b1,2'd1, 1'b0,1'b0,2'd0},
    '{3'd1,1'b0,2'd0,1'b0,6'd3,1'b0, 2'd2,1'b1,2'd0, 1'b0,1'b0,2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Called at a negedge; returns at the negedge after the accepting posedge.
  task automatic do_req(input logic [2:0] s, input logic h, input logic [1:0] w,
                        input logic nv, input logic [5:0] na, input logic wr,
                        input logic dy);
    req_set = s; req_hit = h; req_hit_way = w; req_nvm = nv;
    req_naddr = na; req_write = wr; req_dyn = dy; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n_acc++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 rsp_valid", int'(rsp_valid), 0);
    check("R10 wb_valid", int'(wb_valid), 0);
    check("R10 req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 classes, R2 insertion, R3 promotion, R4 victim, R5 writeback, R6 response
    foreach (VT[i]) begin
      do_req(VT[i].set, VT[i].hit, VT[i].way, VT[i].nvm, VT[i].naddr, VT[i].wr, 1'b0);
      check($sformatf("R6 rsp_valid v%0d", i), int'(rsp_valid), 1);
      check($sformatf("R4 rsp_way v%0d", i), int'(rsp_way), int'(VT[i].e_way));
      check($sformatf("R6 rsp_fill v%0d", i), int'(rsp_fill), int'(VT[i].e_fill));
      check($sformatf("R2 R3 rsp_prio v%0d", i), int'(rsp_prio), int'(VT[i].e_prio));
      check($sformatf("R9 rsp_bypass static v%0d", i), int'(rsp_bypass), 0);
      check($sformatf("R5 wb_valid v%0d", i), int'(wb_valid), int'(VT[i].e_wb));
      if (VT[i].e_wb) begin
        check($sformatf("R5 wb_way v%0d", i), int'(wb_way), int'(VT[i].e_wbway));
        check($sformatf("R5 wb_nvm v%0d", i), int'(wb_nvm), int'(VT[i].e_wbnvm));
        check($sformatf("R5 wb_set v%0d", i), int'(wb_set), int'(VT[i].set));
      end
    end
    @(negedge clk);
    check("R6 rsp_valid drops", int'(rsp_valid), 0);

    // R5: writeback held under back-pressure
    wb_ready = 1'b0;
    for (int k = 0; k < 4; k++) do_req(3'd2, 1'b0, 2'd0, 1'b0, 6'd1, 1'b1, 1'b0);
    do_req(3'd2, 1'b0, 2'd0, 1'b1, 6'd1, 1'b0, 1'b0);
    check("R4 dirty victim way", int'(rsp_way), 0);
    repeat (3) @(negedge clk);
    check("R5 wb held valid", int'(wb_valid), 1);
    check("R5 wb held set", int'(wb_set), 2);
    check("R5 wb held way", int'(wb_way), 0);
    check("R5 wb held nvm", int'(wb_nvm), 0);
    check("R5 req_ready low", int'(req_ready), 0);
    wb_ready = 1'b1;
    @(negedge clk);
    check("R5 wb released", int'(wb_valid), 0);
    check("R5 req_ready back", int'(req_ready), 1);

    // Dynamic policy: align to an epoch boundary
    while (n_acc % EP != 0) do_req(3'd7, 1'b0, 2'd0, 1'b0, 6'd1, 1'b0, 1'b0);
    // Epoch A: class 1 misses only (0 hits) -> bypass class 1 (R7)
    for (int k = 0; k < EP; k++) do_req(3'd3, 1'b0, 2'd0, 1'b0, 6'd8, 1'b0, 1'b0);
    // Epoch B
    do_req(3'd3, 1'b0, 2'd0, 1'b0, 6'd8, 1'b0, 1'b1);
    check("R7 dyn bypass", int'(rsp_bypass), 1);
    check("R9 bypass no fill", int'(rsp_fill), 0);
    check("R9 bypass no wb", int'(wb_valid), 0);
    do_req(3'd3, 1'b0, 2'd0, 1'b0, 6'd8, 1'b0, 1'b0);
    check("R9 static ignores bypass", int'(rsp_bypass), 0);
    check("R9 static fills", int'(rsp_fill), 1);
    check("R4 set3 victim", int'(rsp_way), 0);
    do_req(3'd5, 1'b0, 2'd0, 1'b0, 6'd1, 1'b0, 1'b0);
    for (int k = 0; k < EP - 3; k++) do_req(3'd5, 1'b1, 2'd0, 1'b0, 6'd1, 1'b0, 1'b0);
    // Epoch C: class 0 boosted (R8)
    do_req(3'd6, 1'b0, 2'd0, 1'b0, 6'd1, 1'b0, 1'b0);
    check("R9 static ins no boost", int'(rsp_prio), 1);
    do_req(3'd6, 1'b0, 2'd0, 1'b0, 6'd1, 1'b0, 1'b1);
    check("R8 boosted ins way", int'(rsp_way), 1);
    check("R8 boosted ins", int'(rsp_prio), 2);
    do_req(3'd6, 1'b1, 2'd0, 1'b0, 6'd1, 1'b0, 1'b1);
    check("R8 boosted promo", int'(rsp_prio), 3);

    // R10: reset clears ways and dynamic state
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 rsp_valid after reset", int'(rsp_valid), 0);
    check("R10 req_ready after reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    do_req(3'd0, 1'b0, 2'd0, 1'b0, 6'd1, 1'b0, 1'b0);
    check("R10 ways invalid", int'(rsp_way), 0);
    check("R10 no wb", int'(wb_valid), 0);
    do_req(3'd0, 1'b0, 2'd0, 1'b0, 6'd8, 1'b0, 1'b1);
    check("R10 bypass cleared", int'(rsp_bypass), 0);
    check("R10 fill way1", int'(rsp_way), 1);
    summary();
  end
endmodule